// File: doc/BRIEF.md
# Receive Frame Acceptance Filter

This block sits behind a receive deserializer and decides, frame by frame, whether an incoming frame is kept. The destination address reaches it one byte per cycle, first byte on the wire first. A single-cycle end strobe closes the frame. With that strobe come the frame length in bytes, the count of stray bits beyond the last whole byte, a CRC-error flag and a reset-packet flag. The block then compares the captured address against a programmed station address under the configured acceptance policy. One cycle after the end strobe it presents a keep/drop verdict with a set of event flags for the status logic.

Configuration is static between frames. It comes from an 8-bit mode word and a 48-bit station address. Byte 0 of the station address, the first byte compared, sits in bits [7:0]. The mode word holds a 2-bit acceptance policy, a short-match option that compares only the first five address bytes, a runt-keep option and a reset-packet-keep option. Buffering and CRC computation are done elsewhere.

Top module: `rx_accept_filter`

## Requirements
- R1: While `rst_n` is low, every output is 0. A reset also discards any address bytes captured so far, so a frame that begins after reset is judged only on its own bytes.
- R2: Exactly one cycle after `frame_end` is high, `verdict_valid` pulses high for one cycle with the verdict and events. In every other cycle all outputs are 0.
- R3: With mode bits [1:0] = 00, no frame other than a permitted reset packet is kept.
- R4: With mode bits [1:0] = 01, a frame is kept when its six destination bytes equal the station address (`cfg_station[7:0]` compared with the first byte) or are all 0xFF (broadcast).
- R5: With mode bits [1:0] = 10, a frame is kept if it matches the station address, or is broadcast, or has bit 0 of its first destination byte set (multicast). In mode 01 a multicast frame is dropped.
- R6: With mode bits [1:0] = 11, a frame is kept whatever its address.
- R7: With mode bit 4 set, the station match compares only the first five destination bytes and ignores the sixth. With the bit clear, all six bytes must match.
- R8: A frame with `frame_len` below 64 is a runt. `evt_runt` is raised for it in every case, and it is dropped unless mode bit 3 is set.
- R9: When `frame_rst_pkt` is high, `evt_rstpkt` is raised. Such a frame is kept only when mode bit 2 is set, whatever the address policy.
- R10: A frame with `frame_crc_err` high, or with `frame_bit_rem` nonzero (length not a whole number of bytes), is dropped. It raises `evt_crc` or `evt_align` respectively.
- R11: `evt_good` is high only for a kept frame that is not a runt, not a reset packet and has no CRC or alignment error.
- R12: Mode bits 7, 6 and 5 have no effect on any output.
- R13: A frame that delivered fewer than six destination bytes matches neither the station address nor broadcast. Destination bytes after the sixth are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 8 | Acceptance mode word |
| cfg_station | input | 48 | Station address, byte 0 in bits [7:0] |
| dst_valid | input | 1 | A destination address byte is present |
| dst_byte | input | 8 | Destination address byte |
| frame_end | input | 1 | Frame complete, one-cycle strobe |
| frame_len | input | 16 | Frame length in bytes, valid with `frame_end` |
| frame_bit_rem | input | 3 | Bits beyond the last whole byte, valid with `frame_end` |
| frame_crc_err | input | 1 | CRC check failed, valid with `frame_end` |
| frame_rst_pkt | input | 1 | Frame is a reset packet, valid with `frame_end` |
| verdict_valid | output | 1 | Verdict and events valid this cycle |
| verdict_keep | output | 1 | Frame is kept |
| evt_good | output | 1 | Good frame received |
| evt_runt | output | 1 | Runt frame seen |
| evt_align | output | 1 | Alignment error seen |
| evt_crc | output | 1 | CRC error seen |
| evt_rstpkt | output | 1 | Reset packet seen |

## Verification
The per-frame address state is what can go wrong unseen. A byte counter that skips, or a match flag that does not reload at the frame end, is invisible until the following verdict. It then shows up as a wrong keep bit, exactly one cycle after that frame's end strobe. For that reason frames with matching and non-matching addresses are interleaved, short and over-long address runs are included, and a reset is applied in the middle of an address. The decision logic has no memory, so an error in it shows on the verdict of the very frame that exercises the faulty mode bit.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int ADDR_BYTES = 6;
    localparam int LEN_W      = 16;
    localparam int RUNT_MIN   = 64;

    // mode word bit positions used by the decision logic
    localparam int MODE_SHORT_BIT = 4;
    localparam int MODE_RUNT_BIT  = 3;
    localparam int MODE_RPKT_BIT  = 2;

    typedef enum logic [1:0] {
        POL_NONE  = 2'b00,
        POL_BCAST = 2'b01,
        POL_MCAST = 2'b10,
        POL_ALL   = 2'b11
    } policy_e;

    typedef struct packed {
        logic complete;
        logic own_lead;
        logic own_last;
        logic bcast;
        logic mcast;
    } addr_flags_t;

    typedef struct packed {
        logic keep;
        logic good;
        logic runt;
        logic align;
        logic crc;
        logic rpkt;
    } verdict_t;

endpackage

// File: rtl/rxf_addr_track.sv
module rxf_addr_track
    import rxf_pkg::*;
#(
    parameter int NBYTES = ADDR_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [8*NBYTES-1:0] station,
    input  logic              dst_valid,
    input  logic [7:0]        dst_byte,
    input  logic              frame_end,
    output addr_flags_t       flags
);

    localparam int CNT_W = $clog2(NBYTES + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             own_lead;
        logic             own_last;
        logic             bcast;
        logic             mcast;
    } trk_t;

    localparam trk_t TRK_INIT = '{cnt: '0, own_lead: 1'b1, own_last: 1'b1,
                                  bcast: 1'b1, mcast: 1'b0};

    trk_t trk_d, trk_q;

    // one comparator per station byte
    logic [NBYTES-1:0] byte_hit;
    genvar g;
    generate
        for (g = 0; g < NBYTES; g++) begin : g_cmp
            assign byte_hit[g] = (dst_byte == station[8*g +: 8]);
        end
    endgenerate

    logic sel_hit;
    always_comb begin
        sel_hit = 1'b0;
        for (int i = 0; i < NBYTES; i++) begin
            if (trk_q.cnt == CNT_W'(i)) sel_hit = byte_hit[i];
        end
    end

    always_comb begin
        trk_d = trk_q;
        if (frame_end) begin
            trk_d = TRK_INIT;
        end else if (dst_valid && (trk_q.cnt < CNT_W'(NBYTES))) begin
            if (trk_q.cnt == CNT_W'(NBYTES - 1)) begin
                trk_d.own_last = trk_q.own_last & sel_hit;
            end else begin
                trk_d.own_lead = trk_q.own_lead & sel_hit;
            end
            trk_d.bcast = trk_q.bcast & (dst_byte == 8'hFF);
            if (trk_q.cnt == '0) trk_d.mcast = dst_byte[0];
            trk_d.cnt = trk_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= TRK_INIT;
        else        trk_q <= trk_d;
    end

    assign flags.complete = (trk_q.cnt == CNT_W'(NBYTES));
    assign flags.own_lead = trk_q.own_lead;
    assign flags.own_last = trk_q.own_last;
    assign flags.bcast    = trk_q.bcast;
    assign flags.mcast    = trk_q.mcast;

endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
    import rxf_pkg::*;
(
    input  addr_flags_t      flags,
    input  logic [7:0]       mode,
    input  logic [LEN_W-1:0] len,
    input  logic [2:0]       bit_rem,
    input  logic             crc_err,
    input  logic             rst_pkt,
    output verdict_t         verdict
);

    logic    own_hit, bc_hit, addr_pass, base_pass, runt, align_err;
    policy_e pol;

    always_comb begin
        pol       = policy_e'(mode[1:0]);
        own_hit   = flags.complete & flags.own_lead &
                    (mode[MODE_SHORT_BIT] | flags.own_last);
        bc_hit    = flags.complete & flags.bcast;
        unique case (pol)
            POL_NONE:  addr_pass = 1'b0;
            POL_BCAST: addr_pass = own_hit | bc_hit;
            POL_MCAST: addr_pass = own_hit | bc_hit | flags.mcast;
            default:   addr_pass = 1'b1;
        endcase
        base_pass = rst_pkt ? mode[MODE_RPKT_BIT] : addr_pass;
        runt      = (len < LEN_W'(RUNT_MIN));
        align_err = (bit_rem != 3'd0);

        verdict.keep  = base_pass & ~crc_err & ~align_err &
                        (~runt | mode[MODE_RUNT_BIT]);
        verdict.good  = verdict.keep & ~runt & ~rst_pkt;
        verdict.runt  = runt;
        verdict.align = align_err;
        verdict.crc   = crc_err;
        verdict.rpkt  = rst_pkt;
    end

    logic unused_mode;
    assign unused_mode = ^mode[7:5];

endmodule

// File: rtl/rx_accept_filter.sv
module rx_accept_filter
    import rxf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  cfg_mode,
    input  logic [47:0] cfg_station,
    input  logic        dst_valid,
    input  logic [7:0]  dst_byte,
    input  logic        frame_end,
    input  logic [15:0] frame_len,
    input  logic [2:0]  frame_bit_rem,
    input  logic        frame_crc_err,
    input  logic        frame_rst_pkt,
    output logic        verdict_valid,
    output logic        verdict_keep,
    output logic        evt_good,
    output logic        evt_runt,
    output logic        evt_align,
    output logic        evt_crc,
    output logic        evt_rstpkt
);

    typedef struct packed {
        logic     valid;
        verdict_t v;
    } out_t;

    addr_flags_t flags;
    verdict_t    verdict;
    out_t        out_d, out_q;

    rxf_addr_track #(.NBYTES(ADDR_BYTES)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .station   (cfg_station),
        .dst_valid (dst_valid),
        .dst_byte  (dst_byte),
        .frame_end (frame_end),
        .flags     (flags)
    );

    rxf_decide u_decide (
        .flags   (flags),
        .mode    (cfg_mode),
        .len     (frame_len),
        .bit_rem (frame_bit_rem),
        .crc_err (frame_crc_err),
        .rst_pkt (frame_rst_pkt),
        .verdict (verdict)
    );

    always_comb begin
        out_d = '0;
        if (frame_end) begin
            out_d.valid = 1'b1;
            out_d.v     = verdict;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign verdict_valid = out_q.valid;
    assign verdict_keep  = out_q.v.keep;
    assign evt_good      = out_q.v.good;
    assign evt_runt      = out_q.v.runt;
    assign evt_align     = out_q.v.align;
    assign evt_crc       = out_q.v.crc;
    assign evt_rstpkt    = out_q.v.rpkt;

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] cfg_mode,
    input logic       frame_end,
    input logic       verdict_valid,
    input logic       verdict_keep,
    input logic       evt_good,
    input logic       evt_runt,
    input logic       evt_align,
    input logic       evt_crc,
    input logic       evt_rstpkt
);

    // R2
    verdict_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid |-> $past(frame_end));

    // R2
    quiet_without_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_end) |-> !verdict_valid && !verdict_keep && !evt_good &&
        !evt_runt && !evt_align && !evt_crc && !evt_rstpkt);

    // R11
    good_is_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_good |-> verdict_keep && !evt_runt && !evt_crc && !evt_align && !evt_rstpkt);

    // R10
    error_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_crc || evt_align) |-> !verdict_keep);

    // R3
    none_policy_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_valid && ($past(cfg_mode[1:0]) == 2'b00) && !evt_rstpkt) |-> !verdict_keep);

    // R8
    runt_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_runt && verdict_keep) |-> $past(cfg_mode[3]));

    // R9
    rstpkt_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_rstpkt && verdict_keep) |-> $past(cfg_mode[2]));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> !verdict_valid && !verdict_keep);

endmodule

bind rx_accept_filter rxf_checker u_chk (.*);

// File: tb/rx_accept_filter_bench.sv
module rx_accept_filter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  cfg_mode;
    logic [47:0] cfg_station;
    logic        dst_valid;
    logic [7:0]  dst_byte;
    logic        frame_end;
    logic [15:0] frame_len;
    logic [2:0]  frame_bit_rem;
    logic        frame_crc_err;
    logic        frame_rst_pkt;
    logic        verdict_valid, verdict_keep, evt_good, evt_runt, evt_align, evt_crc, evt_rstpkt;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_accept_filter u_rx_accept_filter (.*);

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    string tag = "R1";
    logic [6:0] exp_vec = '0;
    logic [7:0] pend[$];

    // bit order: valid keep good runt align crc rstpkt
    task automatic step();
        logic [6:0] act;
        @(negedge clk);
        act = {verdict_valid, verdict_keep, evt_good, evt_runt, evt_align, evt_crc, evt_rstpkt};
        checks++;
        if (act !== exp_vec) begin
            failures++;
            $display("FAIL %s: outputs act=%b exp=%b", tag, act, exp_vec);
        end
        exp_vec = '0;
    endtask

    function automatic logic [7:0] stn(int i);
        return cfg_station[8*i +: 8];
    endfunction

    task automatic model_end(int len, bit crc, int rem, bit rp);
        int n = pend.size();
        bit own = (n >= 6), bc = (n >= 6), mc, pass, base, runt, al, keep, good;
        for (int i = 0; i < 6; i++) begin
            if (i < n) begin
                if (pend[i] != stn(i) && !(i == 5 && cfg_mode[4])) own = 0;
                if (pend[i] != 8'hFF) bc = 0;
            end
        end
        mc = (n >= 1) && pend[0][0];
        case (cfg_mode[1:0])
            2'b00: pass = 0;
            2'b01: pass = own || bc;
            2'b10: pass = own || bc || mc;
            default: pass = 1;
        endcase
        base = rp ? cfg_mode[2] : pass;
        runt = (len < 64);
        al   = (rem != 0);
        keep = base && !crc && !al && (!runt || cfg_mode[3]);
        good = keep && !runt && !rp;
        exp_vec = {1'b1, keep, good, runt, al, crc, rp};
        pend.delete();
    endtask

    task automatic send_bytes(logic [7:0] b[$]);
        foreach (b[k]) begin
            dst_valid = 1'b1;
            dst_byte  = b[k];
            pend.push_back(b[k]);
            step();
        end
        dst_valid = 1'b0;
    endtask

    task automatic frame(logic [7:0] b[$], int len, bit crc, int rem, bit rp, string t);
        tag = t;
        send_bytes(b);
        frame_end     = 1'b1;
        frame_len     = 16'(len);
        frame_crc_err = crc;
        frame_bit_rem = 3'(rem);
        frame_rst_pkt = rp;
        model_end(len, crc, rem, rp);
        step();
        frame_end = 1'b0; frame_crc_err = 1'b0; frame_bit_rem = '0; frame_rst_pkt = 1'b0;
        step();
        step();
    endtask

    logic [7:0] own_a[$]  = '{8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC};
    logic [7:0] own_x[$]  = '{8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'h00};
    logic [7:0] own_8[$]  = '{8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC, 8'h55, 8'h66};
    logic [7:0] bc_a[$]   = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    logic [7:0] bc_4[$]   = '{8'hFF, 8'hFF, 8'hFF, 8'hFF};
    logic [7:0] mc_a[$]   = '{8'h01, 8'h00, 8'h5E, 8'h11, 8'h22, 8'h33};
    logic [7:0] oth_a[$]  = '{8'h40, 8'h41, 8'h42, 8'h43, 8'h44, 8'h45};
    logic [7:0] part3[$]  = '{8'h12, 8'h34, 8'h56};

    initial begin
        rst_n = 1'b0;
        cfg_mode = 8'h01; cfg_station = 48'hBC9A_7856_3412;
        dst_valid = 0; dst_byte = 0; frame_end = 0; frame_len = 0;
        frame_bit_rem = 0; frame_crc_err = 0; frame_rst_pkt = 0;
        tag = "R1"; step(); step();
        rst_n = 1'b1; step();

        cfg_mode = 8'h01;
        frame(own_a, 100, 0, 0, 0, "R4 own address");
        frame(bc_a, 100, 0, 0, 0, "R4 broadcast");
        frame(oth_a, 100, 0, 0, 0, "R4 foreign drop");
        frame(mc_a, 100, 0, 0, 0, "R5 multicast in mode 01");
        cfg_mode = 8'h02;
        frame(mc_a, 100, 0, 0, 0, "R5 multicast kept");
        frame(own_a, 100, 0, 0, 0, "R5 own in mode 10");
        cfg_mode = 8'h00;
        frame(own_a, 100, 0, 0, 0, "R3 none");
        frame(bc_a, 100, 0, 0, 0, "R3 none bcast");
        cfg_mode = 8'h03;
        frame(oth_a, 100, 0, 0, 0, "R6 all");
        cfg_mode = 8'h11;
        frame(own_x, 100, 0, 0, 0, "R7 short match");
        cfg_mode = 8'h01;
        frame(own_x, 100, 0, 0, 0, "R7 full match");
        frame(own_a, 40, 0, 0, 0, "R8 runt dropped");
        frame(own_a, 63, 0, 0, 0, "R8 len 63");
        frame(own_a, 64, 0, 0, 0, "R8 len 64");
        cfg_mode = 8'h09;
        frame(own_a, 40, 0, 0, 0, "R8 runt kept");
        cfg_mode = 8'h01;
        frame(oth_a, 100, 0, 0, 1, "R9 reset pkt dropped");
        cfg_mode = 8'h04;
        frame(oth_a, 100, 0, 0, 1, "R9 reset pkt kept");
        cfg_mode = 8'h01;
        frame(own_a, 100, 1, 0, 0, "R10 crc");
        frame(own_a, 100, 0, 3, 0, "R10 align");
        frame(own_a, 100, 0, 0, 0, "R11 good");
        cfg_mode = 8'hE1;
        frame(own_a, 100, 0, 0, 0, "R12 high bits own");
        frame(oth_a, 100, 0, 0, 0, "R12 high bits foreign");
        cfg_mode = 8'h01;
        frame(bc_4, 100, 0, 0, 0, "R13 short bcast");
        frame(own_8, 100, 0, 0, 0, "R13 extra bytes");
        cfg_mode = 8'h03;
        frame(bc_4, 100, 0, 0, 0, "R13 short all");

        // R1: reset in the middle of an address
        cfg_mode = 8'h01;
        tag = "R1 mid reset";
        send_bytes(part3);
        rst_n = 1'b0; pend.delete(); step();
        rst_n = 1'b1; step();
        frame(own_a, 100, 0, 0, 0, "R1 after reset");
        frame(part3, 100, 0, 0, 0, "R1 partial after reset");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: act=running exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule